// File: doc/BRIEF.md
# Predicated Vector-Immediate Compare Unit

This execution unit takes one 32-bit compare-with-immediate instruction word together with a vector operand and a governing predicate. It checks that the word is one of the ten legal compare forms. Six of those forms are signed and four are unsigned. The unit splits the vector into lanes of 8, 16, 32 or 64 bits and compares every lane against the immediate. The immediate is a signed 5-bit value or an unsigned 7-bit value, extended to the lane width in the same way as the lane itself.

The result is a destination predicate that holds one bit per vector byte. The bit for lane `e` sits at the lane's starting byte. A lane that the governing predicate switches off yields 0. The unit also produces four condition flags, which summarise the first active lane, the last active lane and whether any active lane compared true.

Results are registered. They appear one clock after the `in_valid` strobe, together with an `out_valid` pulse, the destination register index and an illegal-encoding pulse. The vector width is a parameter, and the predicate width is that width divided by eight.

Top module: `vcmpi_unit`

## Requirements
- R1: The two bits at word[23:22] select the lane width: 0 selects 8 bits, 1 selects 16, 2 selects 32 and 3 selects 64. The result bit for lane e sits at predicate index e*(width/8), and every other predicate bit is written 0.
- R2: Signed forms have word[31:24]=0x25 and word[21]=0. Their immediate is word[20:16] as a two's-complement value from -16 to 15. Each lane is read as signed. {word[15:13],word[4]} picks the test: 100/0 is equal, 100/1 is not-equal, 000/0 is ≥, 000/1 is >, 001/0 is < and 001/1 is ≤.
- R3: Unsigned forms have word[31:24]=0x24 and word[21]=1. Their immediate is word[20:14], from 0 to 127. Each lane is read as unsigned. {word[13],word[4]} picks the test: 0/0 is ≥, 0/1 is >, 1/0 is < and 1/1 is ≤.
- R4: A lane counts as active only when the governing predicate bit at that lane's starting byte is 1. An inactive lane yields 0 in the result. Governing bits at other positions have no effect.
- R5: N equals the result bit of the lowest-numbered active lane.
- R6: Z is 1 exactly when no active lane compared true.
- R7: C equals the inverse of the result bit of the highest-numbered active lane, and V is always 0.
- R8: When no lane is active, the flags are N=0, Z=1, C=1 and V=0.
- R9: A word that matches neither form raises `illegal` for one cycle. In that case the destination predicate, the flags and the destination index keep their previous values.
- R10: Outputs update on the clock edge that samples `in_valid`. `out_valid` is a one-cycle pulse that follows each strobe, and `dst_idx` takes word[3:0].
- R11: While synchronous reset is high, `out_valid`, `illegal`, `dst_pred`, all flags and `dst_idx` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: word and operands are present |
| instr | input | 32 | Compare instruction word |
| vec_in | input | VLEN | Vector operand |
| gpred_in | input | VLEN/8 | Governing predicate |
| out_valid | output | 1 | Pulse one cycle after each strobe |
| dst_pred | output | VLEN/8 | Destination predicate |
| flag_n | output | 1 | First active lane true |
| flag_z | output | 1 | No active lane true |
| flag_c | output | 1 | Last active lane not true |
| flag_v | output | 1 | Always zero |
| dst_idx | output | 4 | Destination predicate index |
| illegal | output | 1 | Pulse: word was not a legal compare form |

## Verification
The assertions take for granted that reset is held high at the start. They also assume that `instr` size bits and `gpred_in` are meaningful in any cycle where `in_valid` is high, because the checker captures them on that strobe to judge the following result. The stimulus meets these assumptions by driving every input on the falling edge. It also raises `in_valid` for exactly one cycle per operation, with idle cycles in between, so each result sits on the outputs unambiguously before the next strobe.

// File: rtl/vcmpi_pkg.sv
package vcmpi_pkg;

  typedef enum logic [2:0] {
    OP_EQ, OP_NE, OP_GE, OP_GT, OP_LT, OP_LE
  } cmp_op_e;

  typedef struct packed {
    logic       legal;
    logic       is_unsigned;
    cmp_op_e    op;
    logic [1:0] size;
    logic [6:0] imm_raw;
    logic [3:0] pd;
  } dec_t;

  localparam logic [7:0] SGN_MAJOR = 8'b0010_0101;
  localparam logic [7:0] UNS_MAJOR = 8'b0010_0100;

  // Classify a 32-bit word into one of the compare forms.
  function automatic dec_t decode_word(input logic [31:0] w);
    dec_t d;
    logic sgn_hit;
    logic uns_hit;
    sgn_hit       = (w[31:24] == SGN_MAJOR) && !w[21];
    uns_hit       = (w[31:24] == UNS_MAJOR) &&  w[21];
    d.legal       = 1'b0;
    d.is_unsigned = uns_hit;
    d.op          = OP_EQ;
    d.size        = w[23:22];
    d.pd          = w[3:0];
    d.imm_raw     = uns_hit ? w[20:14] : {2'b00, w[20:16]};
    if (sgn_hit) begin
      unique case (w[15:13])
        3'b100:  begin d.legal = 1'b1; d.op = w[4] ? OP_NE : OP_EQ; end
        3'b000:  begin d.legal = 1'b1; d.op = w[4] ? OP_GT : OP_GE; end
        3'b001:  begin d.legal = 1'b1; d.op = w[4] ? OP_LE : OP_LT; end
        default: d.legal = 1'b0;
      endcase
    end else if (uns_hit) begin
      d.legal = 1'b1;
      unique case ({w[13], w[4]})
        2'b00:   d.op = OP_GE;
        2'b01:   d.op = OP_GT;
        2'b10:   d.op = OP_LT;
        default: d.op = OP_LE;
      endcase
    end
    return d;
  endfunction

  // Immediate widened to 65 bits so that 64-bit unsigned lanes compare exactly.
  function automatic logic [64:0] widen_imm(input logic [6:0] raw, input logic uns);
    return uns ? {58'd0, raw} : {{60{raw[4]}}, raw[4:0]};
  endfunction

  // Both operands already widened, one bit past the widest lane.
  function automatic logic cmp_eval(input cmp_op_e op,
                                    input logic signed [64:0] a,
                                    input logic signed [64:0] b);
    logic r;
    unique case (op)
      OP_EQ:   r = (a == b);
      OP_NE:   r = (a != b);
      OP_GE:   r = (a >= b);
      OP_GT:   r = (a >  b);
      OP_LT:   r = (a <  b);
      default: r = (a <= b);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/vcmpi_decode.sv
module vcmpi_decode
  import vcmpi_pkg::*;
(
  input  logic [31:0] word,
  output dec_t        dec,
  output logic [64:0] imm_wide
);

  always_comb begin
    dec      = decode_word(word);
    imm_wide = widen_imm(dec.imm_raw, dec.is_unsigned);
  end

endmodule

// File: rtl/vcmpi_lanes.sv
module vcmpi_lanes
  import vcmpi_pkg::*;
#(
  parameter int VLEN = 256,
  localparam int PLEN = VLEN / 8
) (
  input  logic [VLEN-1:0] vec,
  input  logic [PLEN-1:0] gpred,
  input  logic [1:0]      size,
  input  logic            uns,
  input  cmp_op_e         op,
  input  logic [64:0]     imm_wide,
  output logic [PLEN-1:0] res,
  output logic [PLEN-1:0] act
);

  for (genvar s = 0; s < 4; s++) begin : g_sz
    localparam int EB   = 8 << s;
    localparam int STEP = 1 << s;
    localparam int NEL  = VLEN / EB;

    logic [NEL-1:0]  hit;
    logic [NEL-1:0]  on;
    logic [PLEN-1:0] res_s;
    logic [PLEN-1:0] act_s;

    for (genvar e = 0; e < NEL; e++) begin : g_el
      logic [EB-1:0] elem;
      logic [64:0]   lane_wide;
      assign elem      = vec[e*EB +: EB];
      assign lane_wide = uns ? {{(65-EB){1'b0}}, elem}
                             : {{(65-EB){elem[EB-1]}}, elem};
      assign on[e]     = gpred[e*STEP];
      assign hit[e]    = on[e] & cmp_eval(op, lane_wide, imm_wide);
    end

    always_comb begin
      for (int i = 0; i < PLEN; i++) begin
        if ((i % STEP) == 0) begin
          res_s[i] = hit[i / STEP];
          act_s[i] = on[i / STEP];
        end else begin
          res_s[i] = 1'b0;
          act_s[i] = 1'b0;
        end
      end
    end
  end

  always_comb begin
    unique case (size)
      2'd0:    begin res = g_sz[0].res_s; act = g_sz[0].act_s; end
      2'd1:    begin res = g_sz[1].res_s; act = g_sz[1].act_s; end
      2'd2:    begin res = g_sz[2].res_s; act = g_sz[2].act_s; end
      default: begin res = g_sz[3].res_s; act = g_sz[3].act_s; end
    endcase
  end

endmodule

// File: rtl/vcmpi_flags.sv
module vcmpi_flags #(
  parameter int PLEN = 32
) (
  input  logic [PLEN-1:0] res,
  input  logic [PLEN-1:0] act,
  output logic            first_true,
  output logic            none_true,
  output logic            last_false
);

  always_comb begin
    logic seen;
    seen       = 1'b0;
    first_true = 1'b0;
    last_false = 1'b1;
    for (int i = 0; i < PLEN; i++) begin
      if (act[i]) begin
        if (!seen) first_true = res[i];
        seen       = 1'b1;
        last_false = !res[i];
      end
    end
    none_true = ~|res;
  end

endmodule

// File: rtl/vcmpi_unit.sv
module vcmpi_unit
  import vcmpi_pkg::*;
#(
  parameter int VLEN = 256,
  localparam int PLEN = VLEN / 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [VLEN-1:0] vec_in,
  input  logic [PLEN-1:0] gpred_in,
  output logic            out_valid,
  output logic [PLEN-1:0] dst_pred,
  output logic            flag_n,
  output logic            flag_z,
  output logic            flag_c,
  output logic            flag_v,
  output logic [3:0]      dst_idx,
  output logic            illegal
);

  dec_t            dec;
  logic [64:0]     imm_wide;
  logic [PLEN-1:0] lane_res;
  logic [PLEN-1:0] lane_act;
  logic            nxt_n;
  logic            nxt_z;
  logic            nxt_c;
  logic            op_accept;
  logic            op_reject;

  vcmpi_decode u_dec (
    .word     (instr),
    .dec      (dec),
    .imm_wide (imm_wide)
  );

  vcmpi_lanes #(.VLEN(VLEN)) u_lanes (
    .vec      (vec_in),
    .gpred    (gpred_in),
    .size     (dec.size),
    .uns      (dec.is_unsigned),
    .op       (dec.op),
    .imm_wide (imm_wide),
    .res      (lane_res),
    .act      (lane_act)
  );

  vcmpi_flags #(.PLEN(PLEN)) u_flags (
    .res        (lane_res),
    .act        (lane_act),
    .first_true (nxt_n),
    .none_true  (nxt_z),
    .last_false (nxt_c)
  );

  assign op_accept = in_valid &  dec.legal;
  assign op_reject = in_valid & ~dec.legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      dst_pred  <= '0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_c    <= 1'b0;
      flag_v    <= 1'b0;
      dst_idx   <= '0;
    end else begin
      out_valid <= in_valid;
      illegal   <= op_reject;
      if (op_accept) begin
        dst_pred <= lane_res;
        flag_n   <= nxt_n;
        flag_z   <= nxt_z;
        flag_c   <= nxt_c;
        flag_v   <= 1'b0;
        dst_idx  <= dec.pd;
      end
    end
  end

endmodule

// File: rtl/vcmpi_unit_chk.sv
module vcmpi_unit_chk #(
  parameter int PLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            op_accept,
  input logic [1:0]      sz,
  input logic [PLEN-1:0] gpred_in,
  input logic            out_valid,
  input logic            illegal,
  input logic [PLEN-1:0] dst_pred,
  input logic            flag_n,
  input logic            flag_z,
  input logic            flag_c,
  input logic            flag_v
);

  logic [1:0]      sz_q;
  logic [PLEN-1:0] gp_q;
  logic [PLEN-1:0] emask;
  logic [PLEN-1:0] act_q;

  always_ff @(posedge clk) begin
    if (in_valid) begin
      sz_q <= sz;
      gp_q <= gpred_in;
    end
  end

  always_comb begin
    for (int i = 0; i < PLEN; i++) emask[i] = ((i % (1 << sz_q)) == 0);
    act_q = emask & gp_q;
  end

  a_r10_pulse_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r9_hold_on_reject: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_accept) |=> (illegal && $stable(dst_pred) && $stable(flag_z)));
  a_r1_off_element_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !illegal) |-> ((dst_pred & ~emask) == '0));
  a_r4_inactive_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !illegal) |-> ((dst_pred & ~gp_q) == '0));
  a_r6_z_matches: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !illegal) |-> (flag_z == (dst_pred == '0)));
  a_r8_no_active: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !illegal && act_q == '0) |-> (!flag_n && flag_z && flag_c && !flag_v));
  a_r5_n_needs_true: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !illegal && flag_n) |-> !flag_z);

endmodule

bind vcmpi_unit vcmpi_unit_chk #(.PLEN(PLEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op_accept (op_accept),
  .sz        (instr[23:22]),
  .gpred_in  (gpred_in),
  .out_valid (out_valid),
  .illegal   (illegal),
  .dst_pred  (dst_pred),
  .flag_n    (flag_n),
  .flag_z    (flag_z),
  .flag_c    (flag_c),
  .flag_v    (flag_v)
);

// File: tb/vcmpi_unit_test.sv
module vcmpi_unit_test;

  localparam int VLEN = 256;
  localparam int PLEN = VLEN / 8;
  localparam int NTAB = 24;
  localparam int ROUNDS = 6;

  // entry: {cond[3:0], size[1:0], imm[7:0]}
  // cond: 0 EQ 1 NE 2 GE 3 GT 4 LT 5 LE 6 HS 7 HI 8 LO 9 LS
  localparam logic [13:0] TAB [NTAB] = '{
    {4'd0, 2'd0, 8'hF0}, {4'd1, 2'd1, 8'h0F}, {4'd2, 2'd2, 8'h00}, {4'd3, 2'd3, 8'hF0},
    {4'd4, 2'd0, 8'h0F}, {4'd5, 2'd1, 8'h00}, {4'd6, 2'd2, 8'h7F}, {4'd7, 2'd3, 8'h00},
    {4'd8, 2'd0, 8'h7F}, {4'd9, 2'd1, 8'h7F}, {4'd0, 2'd3, 8'h0F}, {4'd1, 2'd2, 8'hF0},
    {4'd2, 2'd1, 8'hF0}, {4'd3, 2'd0, 8'h0F}, {4'd4, 2'd3, 8'h00}, {4'd5, 2'd2, 8'hF0},
    {4'd6, 2'd0, 8'h00}, {4'd7, 2'd1, 8'h7F}, {4'd8, 2'd2, 8'h00}, {4'd9, 2'd3, 8'h7F},
    {4'd0, 2'd2, 8'h00}, {4'd7, 2'd0, 8'h7F}, {4'd4, 2'd1, 8'hF0}, {4'd9, 2'd0, 8'h00}
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [31:0]     instr = '0;
  logic [VLEN-1:0] vec_in = '0;
  logic [PLEN-1:0] gpred_in = '0;
  logic            out_valid;
  logic [PLEN-1:0] dst_pred;
  logic            flag_n, flag_z, flag_c, flag_v;
  logic [3:0]      dst_idx;
  logic            illegal;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  vcmpi_unit #(.VLEN(VLEN)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .vec_in(vec_in), .gpred_in(gpred_in), .out_valid(out_valid),
    .dst_pred(dst_pred), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .flag_v(flag_v), .dst_idx(dst_idx), .illegal(illegal)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input int cond, input logic [1:0] sz,
                                      input logic [7:0] imm, input logic [3:0] pd);
    logic [31:0] w;
    w = '0;
    w[23:22] = sz;
    w[12:10] = 3'd5;
    w[9:5]   = 5'd17;
    w[3:0]   = pd;
    if (cond < 6) begin
      w[31:24] = 8'h25;
      w[21]    = 1'b0;
      w[20:16] = imm[4:0];
      w[15:13] = (cond < 2) ? 3'b100 : (cond < 4) ? 3'b000 : 3'b001;
      w[4]     = cond[0];
    end else begin
      w[31:24] = 8'h24;
      w[21]    = 1'b1;
      w[20:14] = imm[6:0];
      w[13]    = (cond >= 8);
      w[4]     = cond[0];
    end
    return w;
  endfunction

  // Behavioural reference: loop over lanes with wide signed arithmetic.
  function automatic void model(input logic [31:0] w, input logic [VLEN-1:0] v,
                                input logic [PLEN-1:0] g,
                                output logic [PLEN-1:0] p, output logic [3:0] f);
    logic uns, t, nn, cl, firstdone;
    int cc, sz, eb, nel, pos;
    logic [63:0] raw, m;
    logic signed [65:0] a, b;
    uns = (w[31:24] == 8'h24);
    if (uns) begin
      cc = w[13] ? (w[4] ? 5 : 4) : (w[4] ? 3 : 2);
      b  = {59'd0, w[20:14]};
    end else begin
      cc = (w[15:13] == 3'b100) ? 0 : (w[15:13] == 3'b000) ? 2 : 4;
      cc = cc + int'(w[4]);
      b  = {{61{w[20]}}, w[20:16]};
    end
    sz  = int'(w[23:22]);
    eb  = 8 << sz;
    nel = VLEN / eb;
    m   = (eb == 64) ? '1 : ((64'd1 << eb) - 64'd1);
    p = '0; nn = 1'b0; cl = 1'b1; firstdone = 1'b0;
    for (int e = 0; e < nel; e++) begin
      raw = 64'(v >> (e * eb)) & m;
      if (!uns && raw[eb-1]) raw = raw | ~m;
      a = uns ? {2'b00, raw} : {{2{raw[63]}}, raw};
      case (cc)
        0: t = (a == b);
        1: t = (a != b);
        2: t = (a >= b);
        3: t = (a >  b);
        4: t = (a <  b);
        default: t = (a <= b);
      endcase
      pos = e << sz;
      if (g[pos]) begin
        p[pos] = t;
        if (!firstdone) nn = t;
        firstdone = 1'b1;
        cl = !t;
      end
    end
    f = {nn, (p == '0), cl, 1'b0};
  endfunction

  function automatic logic [VLEN-1:0] make_vec(input logic [1:0] sz, input logic [63:0] base);
    logic [VLEN-1:0] v;
    logic [63:0] ev;
    int eb;
    eb = 8 << sz;
    v = '0;
    for (int e = 0; e < VLEN / eb; e++) begin
      case ($urandom % 4)
        0: ev = base;
        1: ev = base + 64'd1;
        2: ev = base - 64'd1;
        default: ev = {$urandom, $urandom};
      endcase
      for (int k = 0; k < eb / 8; k++) v[(e * eb) + (k * 8) +: 8] = ev[k*8 +: 8];
    end
    return v;
  endfunction

  task automatic issue(input logic [31:0] w, input logic [VLEN-1:0] v, input logic [PLEN-1:0] g);
    @(negedge clk);
    in_valid = 1'b1; instr = w; vec_in = v; gpred_in = g;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [PLEN-1:0] ep, sp;
    logic [3:0]      ef, sf;
    logic [31:0]     w;
    logic [VLEN-1:0] v;
    logic [PLEN-1:0] g;
    logic [63:0]     base;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset outputs", {out_valid, illegal, flag_n, flag_z, flag_c, flag_v, dst_idx}, 64'd0);
    chk("R11 reset pred", 64'(dst_pred), 64'd0);
    @(negedge clk); rst = 1'b0;

    // Table walk: all conditions, all sizes, immediate extremes
    for (int i = 0; i < NTAB; i++) begin
      for (int r = 0; r < ROUNDS; r++) begin
        int cond;
        logic [1:0] sz;
        logic [7:0] imm;
        cond = int'(TAB[i][13:10]);
        sz   = TAB[i][9:8];
        imm  = TAB[i][7:0];
        base = (cond < 6) ? {{59{imm[4]}}, imm[4:0]} : {57'd0, imm[6:0]};
        w = enc(cond, sz, imm, 4'(i + r));
        v = make_vec(sz, base);
        g = (r == 0) ? '1 : (r == 1) ? 32'h8000_0001 : PLEN'($urandom);
        model(w, v, g, ep, ef);
        issue(w, v, g);
        if (cond < 6) chk("R2 R1 R4 signed pred", 64'(dst_pred), 64'(ep));
        else          chk("R3 R1 R4 unsigned pred", 64'(dst_pred), 64'(ep));
        chk("R5 R6 R7 flags", {flag_n, flag_z, flag_c, flag_v}, 64'(ef));
        chk("R10 index and valid", {out_valid, illegal, dst_idx}, {2'b10, 4'(i + r)});
      end
    end

    // R10 output valid lasts one cycle
    @(negedge clk);
    chk("R10 pulse ends", 64'(out_valid), 64'd0);

    // R1 64-bit lanes, unsigned >= 0 is always true: bits 0,8,16,24
    issue(enc(6, 2'd3, 8'h00, 4'd9), {VLEN{1'b1}}, '1);
    chk("R1 wide lane positions", 64'(dst_pred), 64'h0101_0101);
    chk("R7 flags all true", {flag_n, flag_z, flag_c, flag_v}, 64'b1000);

    // R3 byte 0xFF: unsigned > 127 true; R2 signed -1 > -16 true, -1 < 0 true
    issue(enc(7, 2'd0, 8'h7F, 4'd1), {VLEN{1'b1}}, 32'h0000_0001);
    chk("R3 unsigned 0xFF above 127", 64'(dst_pred), 64'd1);
    issue(enc(3, 2'd0, 8'hF0, 4'd1), {VLEN{1'b1}}, 32'h0000_0001);
    chk("R2 signed -1 above -16", 64'(dst_pred), 64'd1);
    issue(enc(4, 2'd0, 8'h00, 4'd1), {VLEN{1'b1}}, 32'h0000_0001);
    chk("R2 signed -1 below 0", 64'(dst_pred), 64'd1);

    // R5/R7: first active true, last active false
    v = '0; v[7:0] = 8'd5;
    issue(enc(0, 2'd0, 8'h05, 4'd2), v, 32'h0000_0011);
    chk("R5 R7 first true last false", {flag_n, flag_z, flag_c, flag_v}, 64'b1010);
    // first false, last true
    v = '0; v[39:32] = 8'd5;
    issue(enc(0, 2'd0, 8'h05, 4'd2), v, 32'h0000_0011);
    chk("R5 R7 first false last true", {flag_n, flag_z, flag_c, flag_v}, 64'b0000);

    // R4 governing bits only at non-start bytes of 32-bit lanes are ignored
    issue(enc(6, 2'd2, 8'h00, 4'd3), '0, 32'hEEEE_EEEE);
    chk("R4 off-position governing bits", 64'(dst_pred), 64'd0);
    chk("R8 no active lane flags", {flag_n, flag_z, flag_c, flag_v}, 64'b0110);

    // R8 empty governing predicate
    issue(enc(1, 2'd0, 8'h0F, 4'd4), {VLEN{1'b1}}, '0);
    chk("R8 empty predicate flags", {flag_n, flag_z, flag_c, flag_v}, 64'b0110);

    // R9 illegal words keep previous state
    issue(enc(6, 2'd3, 8'h00, 4'd7), {VLEN{1'b1}}, '1);
    sp = dst_pred; sf = {flag_n, flag_z, flag_c, flag_v};
    w = enc(0, 2'd0, 8'h00, 4'd12); w[15:13] = 3'b010;
    issue(w, '0, '1);
    chk("R9 illegal op field flag", {illegal, out_valid}, 64'b11);
    chk("R9 pred kept", 64'(dst_pred), 64'(sp));
    chk("R9 flags and index kept", {flag_n, flag_z, flag_c, flag_v, dst_idx}, {sf, 4'd7});
    w = enc(6, 2'd0, 8'h00, 4'd12); w[21] = 1'b0;
    issue(w, '0, '1);
    chk("R9 bad unsigned marker", {illegal, dst_idx, 64'(dst_pred) == 64'(sp)}, {1'b1, 4'd7, 1'b1});
    issue(32'hFFFF_FFFF, '0, '1);
    chk("R9 all-ones word", {illegal, flag_n, flag_z, flag_c, flag_v}, {1'b1, sf});
    @(negedge clk);
    chk("R9 illegal pulse ends", 64'(illegal), 64'd0);

    // R11 reset mid-run clears state
    rst = 1'b1;
    @(negedge clk);
    chk("R11 reset clears", {out_valid, illegal, flag_n, flag_z, flag_c, flag_v, dst_idx, 64'(dst_pred) == 64'd0}, 64'd1);
    rst = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule